// File: doc/BRIEF.md
# Bytecode Fetch and Microcode Entry Translation

This block is the front stage of a stack-machine processor whose program is a stream of byte-wide bytecodes. The bytecodes sit in a small on-chip cache RAM, which is filled through its own write port. A bytecode program counter addresses that RAM. On a fetch strobe, the byte at the counter is latched as the current instruction. A computed lookup table turns that byte into the start address of its microcode routine. The microcode engine sees the registered entry address and the instruction byte on the same cycle, so no trap path is needed.

Every byte that is read, whether it is a bytecode or an inline operand, is also shifted into a 16-bit operand register. Each fetch records the address of the fetched bytecode as a branch base. The branch target is that base plus the sign-extended operand. A jump strobe loads the target into the program counter.

Top module: `bcf_fetch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `jpc_o`, `ir_o`, `uaddr_o`, `opd_o` and `br_target_o` are all zero.
- R2: A write with `wr_en_i` high stores `wr_data_i` at `wr_addr_i` in the bytecode RAM. A later fetch from that address returns the written byte.
- R3: A fetch (`fetch_i` high, `jump_i` low) makes `ir_o` equal, in the next cycle, to the byte stored at the previous `jpc_o`. The same fetch increments `jpc_o` by one, modulo 2^ADDR_W.
- R4: `uaddr_o` changes on the same cycle as `ir_o`. It equals `ir_o` times ENTRY_STRIDE (default 4), taken modulo 2^UADDR_W.
- R5: An operand fetch (`opd_fetch_i` high, `fetch_i` and `jump_i` low) does three things in the next cycle: `opd_o[15:8]` takes the old `opd_o[7:0]`, and `opd_o[7:0]` takes the byte at the old `jpc_o`. `jpc_o` increments by one. `ir_o` and `uaddr_o` are unchanged.
- R6: A fetch also shifts the fetched byte into `opd_o` in the same way as an operand fetch.
- R7: A fetch sets the branch base to the address it read from. An operand fetch leaves the branch base unchanged.
- R8: `br_target_o` equals the branch base plus `opd_o` sign-extended from bit 15, modulo 2^ADDR_W.
- R9: A jump (`jump_i` high) loads `br_target_o` into `jpc_o` for the next cycle. Any fetch or operand-fetch strobe in the same cycle is ignored, so `ir_o`, `uaddr_o` and `opd_o` hold.
- R10: When `fetch_i` and `opd_fetch_i` are both high and `jump_i` is low, only the fetch takes effect: the operand shifts once and `jpc_o` advances once.
- R11: With no strobe high, `jpc_o`, `ir_o`, `uaddr_o`, `opd_o` and `br_target_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_i | input | 1 | Fetch the next bytecode |
| opd_fetch_i | input | 1 | Fetch the next operand byte |
| jump_i | input | 1 | Load the branch target into the program counter |
| wr_en_i | input | 1 | Bytecode RAM write enable |
| wr_addr_i | input | ADDR_W | Bytecode RAM write address |
| wr_data_i | input | 8 | Bytecode RAM write data |
| jpc_o | output | ADDR_W | Bytecode program counter |
| ir_o | output | 8 | Latched bytecode |
| uaddr_o | output | UADDR_W | Microcode entry address of the latched bytecode |
| opd_o | output | 16 | Operand register |
| br_target_o | output | ADDR_W | Branch target address |

## Verification
Every strobe takes effect at one rising edge:
- `jpc_o`, `ir_o`, `uaddr_o` and `opd_o` show the result in the cycle right after that edge.
- `br_target_o` depends only on registered state, so it is valid in that same cycle.

The bench drives each strobe for exactly one edge and samples on the following falling edge. A table of single-strobe steps covers fetch, operand fetch, both strobes together, jump with strobes, and idle, each step carrying its expected outputs. Directed steps then cover reset, negative-offset jumps and counter wraparound at the top of the RAM.

// File: rtl/bcf_pkg.sv
package bcf_pkg;
    localparam int BYTE_W = 8;
    localparam int OPD_W  = 2 * BYTE_W;
    localparam int TBL_N  = 1 << BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [OPD_W-1:0]  opd_t;

    // Action taken at one edge; jump beats fetch, fetch beats operand fetch
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_OPD   = 2'd1,
        ACT_FETCH = 2'd2,
        ACT_JUMP  = 2'd3
    } act_e;

    function automatic act_e pick_act(input logic fetch, input logic opd, input logic jump);
        if (jump)       return ACT_JUMP;
        else if (fetch) return ACT_FETCH;
        else if (opd)   return ACT_OPD;
        else            return ACT_IDLE;
    endfunction
endpackage

// File: rtl/bcf_bcram.sv
module bcf_bcram
    import bcf_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  byte_t             wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_d_i,
    output byte_t             rd_data_o
);
    localparam int DEPTH = 1 << ADDR_W;

    byte_t             mem [DEPTH];
    logic [ADDR_W-1:0] rd_addr_q;

    // Write port used by the cache filler
    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem[wr_addr_i] <= wr_data_i;
        end
    end

    // Registered read address: data follows the counter value of this cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_addr_q <= '0;
        end else begin
            rd_addr_q <= rd_addr_d_i;
        end
    end

    assign rd_data_o = mem[rd_addr_q];
endmodule

// File: rtl/bcf_xlate.sv
module bcf_xlate
    import bcf_pkg::*;
#(
    parameter int UADDR_W      = 10,
    parameter int ENTRY_STRIDE = 4
) (
    input  byte_t               code_i,
    output logic [UADDR_W-1:0]  entry_o
);
    logic [UADDR_W-1:0] tbl [TBL_N];

    function automatic logic [UADDR_W-1:0] entry_of(input int code);
        logic [31:0] prod;
        prod = 32'(code) * 32'(ENTRY_STRIDE);
        return prod[UADDR_W-1:0];
    endfunction

    for (genvar g = 0; g < TBL_N; g++) begin : g_ent
        assign tbl[g] = entry_of(g);
    end

    assign entry_o = tbl[code_i];
endmodule

// File: rtl/bcf_ctrl.sv
module bcf_ctrl
    import bcf_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int UADDR_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_i,
    input  logic               opd_fetch_i,
    input  logic               jump_i,
    input  byte_t              byte_i,
    input  logic [UADDR_W-1:0] entry_i,
    output logic [ADDR_W-1:0]  jpc_d_o,
    output logic [ADDR_W-1:0]  jpc_o,
    output byte_t              ir_o,
    output logic [UADDR_W-1:0] uaddr_o,
    output opd_t               opd_o,
    output logic [ADDR_W-1:0]  target_o
);
    localparam int SUM_W = 32;

    typedef struct packed {
        logic [ADDR_W-1:0]  jpc;
        logic [ADDR_W-1:0]  base;
        byte_t              ir;
        logic [UADDR_W-1:0] uaddr;
        opd_t               opd;
    } st_t;

    st_t               st_d, st_q;
    act_e              act;
    logic [SUM_W-1:0]  opd_ext;
    logic [SUM_W-1:0]  sum;
    logic [ADDR_W-1:0] target;

    // Branch target from registered base and operand
    always_comb begin
        opd_ext = {{(SUM_W-OPD_W){st_q.opd[OPD_W-1]}}, st_q.opd};
        sum     = {{(SUM_W-ADDR_W){1'b0}}, st_q.base} + opd_ext;
        target  = sum[ADDR_W-1:0];
    end

    always_comb begin
        act  = pick_act(fetch_i, opd_fetch_i, jump_i);
        st_d = st_q;
        unique case (act)
            ACT_JUMP: begin
                st_d.jpc = target;
            end
            ACT_FETCH: begin
                st_d.jpc   = st_q.jpc + 1'b1;
                st_d.base  = st_q.jpc;
                st_d.ir    = byte_i;
                st_d.uaddr = entry_i;
                st_d.opd   = {st_q.opd[BYTE_W-1:0], byte_i};
            end
            ACT_OPD: begin
                st_d.jpc = st_q.jpc + 1'b1;
                st_d.opd = {st_q.opd[BYTE_W-1:0], byte_i};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign jpc_d_o  = st_d.jpc;
    assign jpc_o    = st_q.jpc;
    assign ir_o     = st_q.ir;
    assign uaddr_o  = st_q.uaddr;
    assign opd_o    = st_q.opd;
    assign target_o = target;

    // R3
    fetch_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_i && !jump_i) |=> (jpc_o == $past(jpc_o) + 1'b1) && (ir_o == $past(byte_i)));

    // R4
    entry_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_i && !jump_i) |=> uaddr_o == $past(entry_i));

    // R5
    opd_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opd_fetch_i && !fetch_i && !jump_i) |=>
            (opd_o == {$past(opd_o[BYTE_W-1:0]), $past(byte_i)}) && $stable(ir_o));

    // R9
    jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump_i |=> (jpc_o == $past(target_o)) && $stable(opd_o) && $stable(ir_o));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_i && !opd_fetch_i && !jump_i) |=>
            $stable(jpc_o) && $stable(opd_o) && $stable(uaddr_o) && $stable(target_o));
endmodule

// File: rtl/bcf_fetch.sv
module bcf_fetch
    import bcf_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int UADDR_W      = 10,
    parameter int ENTRY_STRIDE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_i,
    input  logic               opd_fetch_i,
    input  logic               jump_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [7:0]         wr_data_i,
    output logic [ADDR_W-1:0]  jpc_o,
    output logic [7:0]         ir_o,
    output logic [UADDR_W-1:0] uaddr_o,
    output logic [15:0]        opd_o,
    output logic [ADDR_W-1:0]  br_target_o
);
    byte_t              rd_byte;
    logic [ADDR_W-1:0]  jpc_d;
    logic [UADDR_W-1:0] entry;

    bcf_bcram #(.ADDR_W(ADDR_W)) u_ram (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .rd_addr_d_i (jpc_d),
        .rd_data_o   (rd_byte)
    );

    bcf_xlate #(.UADDR_W(UADDR_W), .ENTRY_STRIDE(ENTRY_STRIDE)) u_xlate (
        .code_i  (rd_byte),
        .entry_o (entry)
    );

    bcf_ctrl #(.ADDR_W(ADDR_W), .UADDR_W(UADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_i     (fetch_i),
        .opd_fetch_i (opd_fetch_i),
        .jump_i      (jump_i),
        .byte_i      (rd_byte),
        .entry_i     (entry),
        .jpc_d_o     (jpc_d),
        .jpc_o       (jpc_o),
        .ir_o        (ir_o),
        .uaddr_o     (uaddr_o),
        .opd_o       (opd_o),
        .target_o    (br_target_o)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (jpc_o == '0) && (opd_o == '0) && (ir_o == '0));
endmodule

// File: tb/tb_bcf_fetch.sv
module tb_bcf_fetch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_i = 1'b0, opd_fetch_i = 1'b0, jump_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [9:0]  wr_addr_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic [9:0]  jpc_o, br_target_o, uaddr_o;
    logic [7:0]  ir_o;
    logic [15:0] opd_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    bcf_fetch dut (
        .clk(clk), .rst_n(rst_n), .fetch_i(fetch_i), .opd_fetch_i(opd_fetch_i),
        .jump_i(jump_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .jpc_o(jpc_o), .ir_o(ir_o), .uaddr_o(uaddr_o), .opd_o(opd_o),
        .br_target_o(br_target_o)
    );

    typedef struct packed {
        logic        f, o, j;
        logic [9:0]  jpc;
        logic [7:0]  ir;
        logic [9:0]  ua;
        logic [15:0] opd;
        logic [9:0]  br;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b0, 10'd1, 8'h10, 10'h040, 16'h0010, 10'h010},  // R3 R4 R6
        '{1'b0,1'b1,1'b0, 10'd2, 8'h10, 10'h040, 16'h1099, 10'h099},  // R5
        '{1'b1,1'b0,1'b0, 10'd3, 8'h00, 10'h000, 16'h9900, 10'h102},  // R7 R8
        '{1'b0,1'b1,1'b0, 10'd4, 8'h00, 10'h000, 16'h0005, 10'h007},  // R5 R7
        '{1'b1,1'b1,1'b0, 10'd5, 8'hA7, 10'h29C, 16'h05A7, 10'h1AB},  // R10
        '{1'b0,1'b1,1'b0, 10'd6, 8'hA7, 10'h29C, 16'hA7FF, 10'h003},  // R8
        '{1'b0,1'b1,1'b0, 10'd7, 8'hA7, 10'h29C, 16'hFFFE, 10'h002},  // R8
        '{1'b1,1'b1,1'b1, 10'd2, 8'hA7, 10'h29C, 16'hFFFE, 10'h002},  // R9
        '{1'b0,1'b0,1'b0, 10'd2, 8'hA7, 10'h29C, 16'hFFFE, 10'h002},  // R11
        '{1'b1,1'b0,1'b0, 10'd3, 8'h00, 10'h000, 16'hFE00, 10'h202},  // R2 R3
        '{1'b0,1'b1,1'b0, 10'd4, 8'h00, 10'h000, 16'h0005, 10'h007},  // R5
        '{1'b0,1'b0,1'b1, 10'd7, 8'h00, 10'h000, 16'h0005, 10'h007},  // R9
        '{1'b1,1'b0,1'b0, 10'd8, 8'h3C, 10'h0F0, 16'h053C, 10'h143}   // R4 R7
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic ram_wr(input int addr, input int data);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 10'(addr); wr_data_i = 8'(data);
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    // One strobe edge, then sample on the following falling edge
    task automatic step(input logic f, input logic o, input logic j);
        fetch_i = f; opd_fetch_i = o; jump_i = j;
        @(negedge clk);
        fetch_i = 1'b0; opd_fetch_i = 1'b0; jump_i = 1'b0;
    endtask

    task automatic check_all(input string req, input int jpc, input int ir, input int ua,
                             input int opd, input int br);
        chk(req, "jpc", int'(jpc_o), jpc);
        chk(req, "ir", int'(ir_o), ir);
        chk(req, "uaddr", int'(uaddr_o), ua);
        chk(req, "opd", int'(opd_o), opd);
        chk(req, "br_target", int'(br_target_o), br);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1", 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1", 0, 0, 0, 0, 0);

        // R2: fill the program
        ram_wr(0, 8'h10); ram_wr(1, 8'h99); ram_wr(2, 8'h00); ram_wr(3, 8'h05);
        ram_wr(4, 8'hA7); ram_wr(5, 8'hFF); ram_wr(6, 8'hFE); ram_wr(7, 8'h3C);
        check_all("R11", 0, 0, 0, 0, 0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].f, VEC[i].o, VEC[i].j);
            check_all($sformatf("R3-R11 vec%0d", i), int'(VEC[i].jpc), int'(VEC[i].ir),
                      int'(VEC[i].ua), int'(VEC[i].opd), int'(VEC[i].br));
        end

        // R1: reset from a busy state
        rst_n = 1'b0;
        @(negedge clk);
        check_all("R1", 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R8 R9 R3: jump to the top address and wrap
        ram_wr(0, 8'hFF); ram_wr(1, 8'hFF); ram_wr(1023, 8'h81);
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        check_all("R8", 2, 0, 0, 16'hFFFF, 10'h3FF);
        step(1'b0, 1'b0, 1'b1);
        chk("R9", "jpc", int'(jpc_o), 10'h3FF);
        step(1'b1, 1'b0, 1'b0);
        check_all("R3 wrap", 0, 8'h81, 10'h204, 16'hFF81, 10'h380);
        step(1'b0, 1'b0, 1'b0);
        check_all("R11", 0, 8'h81, 10'h204, 16'hFF81, 10'h380);

        finish_run();
    end
endmodule